// File: doc/BRIEF.md
# DSP Miscellaneous-Instruction Execution Unit

This unit executes the housekeeping instructions of a small 16-bit DSP: register-to-register moves, long and short immediate loads, address-register stepping and indexing, and the instructions that set or clear bits of the status word. Each instruction arrives as a 16-bit opcode. Two-word instructions also carry the second fetched word on a separate input. The unit decodes the opcode in the cycle it is accepted. In that same cycle it drives two combinational read ports of an external 32-entry register file. Its write port is committed by the file on the same clock edge that accepts the instruction. The status word is held inside the unit and is visible as a plain output.

The instruction input uses valid/ready. `in_ready` is low while reset is held. It rises in the first cycle after reset and stays high, so the unit never applies back-pressure. An instruction is taken on every rising edge where `in_valid` and `in_ready` are both high. Back-to-back instructions are taken on consecutive edges. A write made by one instruction is visible to the reads of the next one. `done` pulses for one cycle after each accepted instruction.

The register-file index map works as follows. Address registers are 0..3 and index registers are 4..7. Accumulator high words are 0x10/0x11, accumulator low words are 0x1C/0x1D, and accumulator middle words are 0x1E/0x1F. In 40-bit mode, a write to a middle word also raises `acx_we`. The file must then, on the same edge, load the high word of accumulator `acx_sel` with sixteen copies of `acx_sign` and clear its low word.

Top module: `dspm_exec`

## Requirements
- R1: `in_ready` is 0 during reset and 1 from the first cycle after it. An instruction is accepted on an edge with `in_valid`=1 and `in_ready`=1, its register write lands on that same edge, and `done` is 1 in exactly the cycle after each accepted instruction.
- R2: Opcode 0001_11dd_ddds_ssss copies register s (bits [4:0]) into register d (bits [9:5]). A source other than 0x1E/0x1F is copied unchanged.
- R3: A move from 0x1E+k in 40-bit mode checks whether high word 0x10+k equals sixteen copies of bit 15 of the middle word. If it does not, the move yields 0x8000 when bit 15 of the high word is 1, and 0x7FFF otherwise. In every other case the raw middle word is moved.
- R4: Opcode 0000_0000_100d_dddd writes the second instruction word `in_imm` into register d.
- R5: Opcode 0000_1ddd_iiii_iiii writes the 8-bit immediate, sign-extended to 16 bits, into register 0x18+ddd.
- R6: Moves and both immediate loads can write middle word 0x1E+k. When status bit 14 is 1, such a write also sets high word 0x10+k to sixteen copies of bit 15 of the written value and sets low word 0x1C+k to 0. When status bit 14 is 0, only the middle word changes.
- R7: Opcodes 0000_0000_0000_01dd and 0000_0000_0000_10dd decrement and increment address register d modulo 2^16.
- R8: Opcode 0000_0000_0001_ssdd adds index register 4+s to address register d. Opcode 0000_0000_0000_11dd subtracts index register 4+d from address register d. Both wrap modulo 2^16.
- R9: Opcode 0001_0010_xxxx_xiii sets status bit iii+6, and 0001_0011_xxxx_xiii clears it. Bits marked x are ignored.
- R10: For opcode 1000_ffff_xxxx_xxxx the ffff field acts as follows: 0xA clears status bit 13, 0xB sets bit 13, 0xC clears bit 15, 0xD sets bit 15, 0xE clears bit 14 (16-bit mode), and 0xF sets bit 14 (40-bit mode). Any other value changes nothing.
- R11: Opcode 1000_x000_xxxx_xxxx and opcodes matching no pattern above write no register and leave the status word unchanged, but still pulse `done`.
- R12: Reset clears the status word to 0 and holds `done` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Unit can take an instruction |
| in_opcode | input | 16 | First instruction word |
| in_imm | input | 16 | Second instruction word (long immediate) |
| done | output | 1 | One-cycle pulse after each accepted instruction |
| rf_raddr_a | output | 5 | Register-file read index A |
| rf_rdata_a | input | 16 | Data at index A, combinational |
| rf_raddr_b | output | 5 | Register-file read index B |
| rf_rdata_b | input | 16 | Data at index B, combinational |
| rf_we | output | 1 | Write strobe |
| rf_waddr | output | 5 | Write index |
| rf_wdata | output | 16 | Write data |
| acx_we | output | 1 | Accumulator extension strobe |
| acx_sel | output | 1 | Accumulator being extended |
| acx_sign | output | 1 | Sign copied into the high word |
| sr | output | 16 | Status word |

## Verification
Address arithmetic is tried with registers at 0xFFFF, 0x0000 and 0x8000 and with positive, negative and maximum index values. These patterns separate modular wrap from saturation and signed indexing from unsigned. Middle-word writes are issued in both modes and with both signs. This shows whether extension depends on the mode bit and whether the correct accumulator's high and low words are touched. Saturated moves use high words that fit, overflow positively and overflow negatively, and are then repeated in 16-bit mode. Every status-bit position, the flag group, no-ops with junk bits, and long back-to-back runs mixed with idle gaps cover the handshake and read-after-write ordering.

// File: rtl/dspm_pkg.sv
package dspm_pkg;
  typedef enum logic [3:0] {
    OP_NONE, OP_MOVE, OP_LDI, OP_LDS, OP_DEC, OP_INC,
    OP_ADDX, OP_SUBX, OP_BSET, OP_BCLR, OP_FLAG
  } op_e;

  // status bit positions
  localparam int SR_MULMOD = 13;
  localparam int SR_M40    = 14;
  localparam int SR_UNS    = 15;
  localparam int SR_BITOFS = 6;

  // register index prefixes (upper four bits, low bit picks accumulator)
  localparam logic [3:0] IDX_ACH = 4'h8;
  localparam logic [3:0] IDX_ACL = 4'hE;
  localparam logic [3:0] IDX_ACM = 4'hF;
  localparam logic [2:0] IDX_IX  = 3'b001;
endpackage

// File: rtl/dspm_decode.sv
module dspm_decode
  import dspm_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [15:0]   opc,
  output op_e           op,
  output logic [AW-1:0] dst,
  output logic [AW-1:0] srca,
  output logic [AW-1:0] srcb,
  output logic [2:0]    bitsel,
  output logic [3:0]    flag
);
  localparam int PAD = AW - 2;

  always_comb begin
    op     = OP_NONE;
    dst    = '0;
    srca   = '0;
    srcb   = '0;
    bitsel = opc[2:0];
    flag   = opc[11:8];
    if (opc[15:10] == 6'b000111) begin
      op   = OP_MOVE;
      dst  = opc[9:5];
      srca = opc[4:0];
      srcb = {IDX_ACH, opc[0]};
    end else if (opc[15:5] == 11'b00000000100) begin
      op  = OP_LDI;
      dst = opc[4:0];
    end else if (opc[15:11] == 5'b00001) begin
      op  = OP_LDS;
      dst = {2'b11, opc[10:8]};
    end else if (opc[15:4] == 12'h001) begin
      op   = OP_ADDX;
      dst  = {{PAD{1'b0}}, opc[1:0]};
      srca = {{PAD{1'b0}}, opc[1:0]};
      srcb = {IDX_IX, opc[3:2]};
    end else if (opc[15:4] == 12'h000) begin
      dst  = {{PAD{1'b0}}, opc[1:0]};
      srca = {{PAD{1'b0}}, opc[1:0]};
      srcb = {IDX_IX, opc[1:0]};
      unique case (opc[3:2])
        2'b01:   op = OP_DEC;
        2'b10:   op = OP_INC;
        2'b11:   op = OP_SUBX;
        default: op = OP_NONE;
      endcase
    end else if (opc[15:8] == 8'h12) begin
      op = OP_BSET;
    end else if (opc[15:8] == 8'h13) begin
      op = OP_BCLR;
    end else if (opc[15:12] == 4'h8) begin
      op = OP_FLAG;
    end
  end
endmodule

// File: rtl/dspm_sat.sv
module dspm_sat #(
  parameter int W = 16
) (
  input  logic         en,
  input  logic         mode40,
  input  logic [W-1:0] mid,
  input  logic [W-1:0] high,
  output logic [W-1:0] value
);
  logic fits;
  assign fits = (high == {W{mid[W-1]}});

  always_comb begin
    value = mid;
    if (en && mode40 && !fits)
      value = high[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
  end
endmodule

// File: rtl/dspm_status.sv
module dspm_status
  import dspm_pkg::*;
#(
  parameter int SR_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            accept,
  input  op_e             op,
  input  logic [2:0]      bitsel,
  input  logic [3:0]      flag,
  output logic [SR_W-1:0] sr
);
  logic [SR_W-1:0] bmask;
  logic [SR_W-1:0] sr_next;

  assign bmask = SR_W'(1) << ({1'b0, bitsel} + 4'(SR_BITOFS));

  always_comb begin
    sr_next = sr;
    unique case (op)
      OP_BSET: sr_next = sr | bmask;
      OP_BCLR: sr_next = sr & ~bmask;
      OP_FLAG: begin
        unique case (flag)
          4'hA:    sr_next[SR_MULMOD] = 1'b0;
          4'hB:    sr_next[SR_MULMOD] = 1'b1;
          4'hC:    sr_next[SR_UNS]    = 1'b0;
          4'hD:    sr_next[SR_UNS]    = 1'b1;
          4'hE:    sr_next[SR_M40]    = 1'b0;
          4'hF:    sr_next[SR_M40]    = 1'b1;
          default: sr_next = sr;
        endcase
      end
      default: sr_next = sr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         sr <= '0;
    else if (accept) sr <= sr_next;
  end
endmodule

// File: rtl/dspm_exec.sv
module dspm_exec
  import dspm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int RF_AW  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [15:0]       in_opcode,
  input  logic [DATA_W-1:0] in_imm,
  output logic              done,
  output logic [RF_AW-1:0]  rf_raddr_a,
  input  logic [DATA_W-1:0] rf_rdata_a,
  output logic [RF_AW-1:0]  rf_raddr_b,
  input  logic [DATA_W-1:0] rf_rdata_b,
  output logic              rf_we,
  output logic [RF_AW-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              acx_we,
  output logic              acx_sel,
  output logic              acx_sign,
  output logic [15:0]       sr
);
  localparam int SHORT_W = 8;

  logic              ready_q;
  logic              accept;
  op_e               op;
  logic [RF_AW-1:0]  dst, srca, srcb;
  logic [2:0]        bitsel;
  logic [3:0]        flag;
  logic              acm_src;
  logic [DATA_W-1:0] moved;
  logic [DATA_W-1:0] wval;
  logic              writes;

  assign in_ready = ready_q;
  assign accept   = in_valid && ready_q;

  dspm_decode #(.AW(RF_AW)) u_dec (
    .opc(in_opcode), .op(op), .dst(dst), .srca(srca), .srcb(srcb),
    .bitsel(bitsel), .flag(flag)
  );

  assign acm_src = (op == OP_MOVE) && (srca[RF_AW-1:1] == IDX_ACM);

  dspm_sat #(.W(DATA_W)) u_sat (
    .en(acm_src), .mode40(sr[SR_M40]), .mid(rf_rdata_a),
    .high(rf_rdata_b), .value(moved)
  );

  dspm_status #(.SR_W(16)) u_sr (
    .clk(clk), .rst(rst), .accept(accept), .op(op),
    .bitsel(bitsel), .flag(flag), .sr(sr)
  );

  always_comb begin
    writes = 1'b1;
    wval   = '0;
    unique case (op)
      OP_MOVE: wval = moved;
      OP_LDI:  wval = in_imm;
      OP_LDS:  wval = {{(DATA_W-SHORT_W){in_opcode[SHORT_W-1]}}, in_opcode[SHORT_W-1:0]};
      OP_DEC:  wval = rf_rdata_a - DATA_W'(1);
      OP_INC:  wval = rf_rdata_a + DATA_W'(1);
      OP_ADDX: wval = rf_rdata_a + rf_rdata_b;
      OP_SUBX: wval = rf_rdata_a - rf_rdata_b;
      default: writes = 1'b0;
    endcase
  end

  assign rf_raddr_a = srca;
  assign rf_raddr_b = srcb;
  assign rf_we      = accept && writes;
  assign rf_waddr   = dst;
  assign rf_wdata   = wval;
  assign acx_we     = rf_we && (dst[RF_AW-1:1] == IDX_ACM) && sr[SR_M40];
  assign acx_sel    = dst[0];
  assign acx_sign   = wval[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      done    <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      done    <= accept;
    end
  end
endmodule

// File: rtl/dspm_exec_chk.sv
module dspm_exec_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic [15:0] in_opcode,
  input logic        done,
  input logic        rf_we,
  input logic [4:0]  rf_waddr,
  input logic        acx_we,
  input logic [15:0] sr
);
  logic acc;
  assign acc = in_valid && in_ready;

  // R1
  done_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> done);
  // R1
  done_only_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !done);
  // R1
  ready_stays_high_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> in_ready);
  // R1
  write_needs_accept_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> acc);
  // R6
  ext_on_mid_40_chk: assert property (@(posedge clk) disable iff (rst)
    acx_we |-> (rf_we && rf_waddr[4:1] == 4'hF && sr[14]));
  // R9
  bit_set_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && in_opcode[15:8] == 8'h12) |=>
      (sr == ($past(sr) | (16'h0040 << $past(in_opcode[2:0])))));
  // R11
  nop_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && in_opcode[15:12] == 4'h8 && in_opcode[10:8] == 3'b000) |-> !rf_we);
  // R11
  sr_idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !acc |=> $stable(sr));
endmodule

bind dspm_exec dspm_exec_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_opcode(in_opcode), .done(done), .rf_we(rf_we), .rf_waddr(rf_waddr),
  .acx_we(acx_we), .sr(sr)
);

// File: tb/dspm_exec_bench.sv
module dspm_exec_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_opcode = 16'h0;
  logic [15:0] in_imm = 16'h0;
  logic        in_ready, done;
  logic [4:0]  rf_raddr_a, rf_raddr_b, rf_waddr;
  logic [15:0] rf_rdata_a, rf_rdata_b, rf_wdata, sr;
  logic        rf_we, acx_we, acx_sel, acx_sign;

  always #2.5 clk = ~clk;

  dspm_exec u_dspm_exec (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_imm(in_imm), .done(done),
    .rf_raddr_a(rf_raddr_a), .rf_rdata_a(rf_rdata_a),
    .rf_raddr_b(rf_raddr_b), .rf_rdata_b(rf_rdata_b),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .acx_we(acx_we), .acx_sel(acx_sel), .acx_sign(acx_sign), .sr(sr)
  );

  function automatic logic [15:0] preset(input int i);
    case (i)
      0: return 16'hFFFF;  1: return 16'h0000;
      2: return 16'h1234;  3: return 16'h8000;
      4: return 16'h0002;  5: return 16'hFFFE;
      6: return 16'h7FFF;  7: return 16'h0001;
      default: return 16'(i * 16'h0101 + 16'h0300);
    endcase
  endfunction

  // environment register file, written by the unit
  logic [15:0] rf [32];
  assign rf_rdata_a = rf[rf_raddr_a];
  assign rf_rdata_b = rf[rf_raddr_b];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) rf[i] <= preset(i);
    end else begin
      if (rf_we) rf[rf_waddr] <= rf_wdata;
      if (acx_we) begin
        rf[{4'h8, acx_sel}] <= {16{acx_sign}};
        rf[{4'hE, acx_sel}] <= 16'h0;
      end
    end
  end

  // behavioural reference
  logic [15:0] mrf [32];
  logic [15:0] msr;
  logic        mdone, mready;
  string       cur_tag = "R12", mtag = "R12";
  always @(posedge clk) begin
    logic [15:0] v, h, o;
    logic [4:0]  wa, s;
    logic        hw, m40;
    if (rst) begin
      for (int i = 0; i < 32; i++) mrf[i] <= preset(i);
      msr <= 16'h0; mdone <= 1'b0; mready <= 1'b0;
    end else begin
      mready <= 1'b1;
      mdone  <= in_valid && mready;
      if (in_valid && mready) begin
        mtag <= cur_tag;
        o = in_opcode; m40 = msr[14]; hw = 1'b0; wa = 5'd0; v = 16'h0;
        if (o[15:10] == 6'b000111) begin
          s = o[4:0]; wa = o[9:5]; v = mrf[s]; hw = 1'b1;
          if (s >= 5'd30 && m40) begin
            h = mrf[s - 5'd14];
            if (h != {16{v[15]}}) v = h[15] ? 16'h8000 : 16'h7FFF;
          end
        end else if (o[15:5] == 11'b00000000100) begin
          wa = o[4:0]; v = in_imm; hw = 1'b1;
        end else if (o[15:11] == 5'b00001) begin
          wa = 5'd24 + 5'(o[10:8]); v = 16'($signed(o[7:0])); hw = 1'b1;
        end else if (o[15:4] == 12'h001) begin
          wa = 5'(o[1:0]); v = mrf[wa] + mrf[4 + o[3:2]]; hw = 1'b1;
        end else if (o[15:4] == 12'h000 && o[3:2] != 2'b00) begin
          wa = 5'(o[1:0]); hw = 1'b1;
          if (o[3:2] == 2'b01)      v = mrf[wa] - 16'd1;
          else if (o[3:2] == 2'b10) v = mrf[wa] + 16'd1;
          else                      v = mrf[wa] - mrf[4 + o[1:0]];
        end else if (o[15:8] == 8'h12) begin
          msr[o[2:0] + 6] <= 1'b1;
        end else if (o[15:8] == 8'h13) begin
          msr[o[2:0] + 6] <= 1'b0;
        end else if (o[15:12] == 4'h8) begin
          case (o[11:8])
            4'hA: msr[13] <= 1'b0;
            4'hB: msr[13] <= 1'b1;
            4'hC: msr[15] <= 1'b0;
            4'hD: msr[15] <= 1'b1;
            4'hE: msr[14] <= 1'b0;
            4'hF: msr[14] <= 1'b1;
            default: ;
          endcase
        end
        if (hw) begin
          mrf[wa] <= v;
          if (wa >= 5'd30 && m40) begin
            mrf[wa - 5'd14] <= {16{v[15]}};
            mrf[wa - 5'd2]  <= 16'h0;
          end
        end
      end
    end
  end

  int nchk = 0, nfail = 0;
  logic started = 1'b0;
  always @(posedge clk) started <= 1'b1;

  always @(negedge clk) begin
    if (started) begin
      nchk++;
      if (done !== mdone) begin
        nfail++; $display("FAIL %s done actual %0b expected %0b", mtag, done, mdone);
      end
      nchk++;
      if (in_ready !== mready) begin
        nfail++; $display("FAIL R1 in_ready actual %0b expected %0b", in_ready, mready);
      end
      nchk++;
      if (sr !== msr) begin
        nfail++; $display("FAIL %s sr actual %h expected %h", mtag, sr, msr);
      end
      nchk++;
      for (int i = 0; i < 32; i++) begin
        if (rf[i] !== mrf[i]) begin
          nfail++;
          $display("FAIL %s reg %0d actual %h expected %h", mtag, i, rf[i], mrf[i]);
          break;
        end
      end
    end
  end

  task automatic issue(input string tag, input logic [15:0] op, input logic [15:0] imm);
    @(negedge clk);
    in_valid = 1'b1; in_opcode = op; in_imm = imm; cur_tag = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    // R12 reset state, with a pending instruction ignored by R1
    in_valid = 1'b1; in_opcode = 16'h8F00;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b0;
    idle(2);
    // R2 plain moves
    issue("R2", 16'h1C00 | (16'd9 << 5) | 16'd8, 16'h0);
    issue("R2", 16'h1C00 | (16'd20 << 5) | 16'd2, 16'h0);
    idle(1);
    // R11 no-ops, empty flag codes, undefined opcodes
    issue("R11", 16'h8000, 16'h0);
    issue("R11", 16'h88FF, 16'h0);
    issue("R11", 16'h8700, 16'h0);
    issue("R11", 16'h0000, 16'h0);
    issue("R11", 16'h0003, 16'h0);
    // R4 long immediate
    issue("R4", 16'h0080 | 16'h0C, 16'hBEEF);
    issue("R4", 16'h0080 | 16'h1E, 16'h8001);   // R6 16-bit mode: no extension
    // R5 short immediate
    issue("R5", 16'h0A85, 16'h0);
    issue("R5", 16'h097F, 16'h0);
    idle(1);
    // R10 enter 40-bit mode, R6 extension
    issue("R10", 16'h8F00, 16'h0);
    issue("R6", 16'h0080 | 16'h1E, 16'h8001);
    issue("R6", 16'h0F05, 16'h0);
    issue("R6", 16'h1C00 | (16'd31 << 5) | 16'd9, 16'h0);
    // R3 saturated moves
    issue("R3", 16'h0080 | 16'h10, 16'h0001);
    issue("R3", 16'h1C00 | (16'd8 << 5) | 16'd30, 16'h0);
    issue("R3", 16'h0080 | 16'h10, 16'hFFFE);
    issue("R3", 16'h1C00 | (16'd8 << 5) | 16'd30, 16'h0);
    issue("R3", 16'h0F05, 16'h0);
    issue("R3", 16'h1C00 | (16'd12 << 5) | 16'd31, 16'h0);
    issue("R3", 16'h8E00, 16'h0);
    issue("R3", 16'h0080 | 16'h10, 16'h0001);
    issue("R3", 16'h1C00 | (16'd8 << 5) | 16'd30, 16'h0);
    idle(2);
    // R7 step with wrap
    issue("R7", 16'h0005, 16'h0);
    issue("R7", 16'h0008, 16'h0);
    issue("R7", 16'h0008, 16'h0);
    issue("R7", 16'h0006, 16'h0);
    // R8 indexing
    issue("R8", 16'h0010 | (16'd1 << 2) | 16'd2, 16'h0);
    issue("R8", 16'h0010 | (16'd2 << 2) | 16'd3, 16'h0);
    issue("R8", 16'h0010 | (16'd2 << 2) | 16'd3, 16'h0);
    issue("R8", 16'h000C, 16'h0);
    issue("R8", 16'h000D, 16'h0);
    idle(1);
    // R9 every status bit, junk bits set
    for (int i = 0; i < 8; i++) issue("R9", 16'h12F8 | 16'(i), 16'h0);
    issue("R9", 16'h1303, 16'h0);
    issue("R9", 16'h13F8, 16'h0);
    issue("R9", 16'h1307, 16'h0);
    idle(1);
    // R10 flag group
    for (int f = 10; f < 16; f++) issue("R10", 16'h8000 | 16'(f << 8), 16'h0);
    issue("R10", 16'h8A00, 16'h0);
    issue("R10", 16'h8C00, 16'h0);
    issue("R10", 16'h8900, 16'h0);
    // R1 burst with read-after-write and gaps
    issue("R1", 16'h0080 | 16'h01, 16'h00F0);
    issue("R1", 16'h0009, 16'h0);
    idle(1);
    issue("R1", 16'h1C00 | (16'd5 << 5) | 16'd1, 16'h0);
    issue("R1", 16'h0011 | (16'd1 << 2), 16'h0);
    idle(4);
    finish_up();
  end
endmodule